// File: doc/BRIEF.md
# SPI Register-File Slave with Burst Access

This block lets an external SPI master read and write a small byte-wide register file. A transaction is one chip-select window. The first byte the master sends is a command byte. Its top bit selects read or write, and its low bits give a start address. Every later byte either stores the incoming data at the current address or returns the register at that address. The address advances by one after each data byte, so one transaction can move a whole run of registers.

The SPI pins use mode 0: the block samples MOSI on the rising SCLK edge and updates MISO after the falling edge, most significant bit first. SCLK, MOSI and chip-select are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than SCLK. Local logic reads any register at any time through a separate combinational read port.

Top module: `spi_regfile_slave`

## Requirements
- R1: After reset every one of the 64 registers reads 0x00 and MISO is 0.
- R2: A command byte with bit 7 = 0 starts a write burst at address bits 6:0. Each following complete byte is stored at the current address, and the address then increments by one.
- R3: A command byte with bit 7 = 1 starts a read burst at address bits 6:0. Each following 8-clock byte slot returns the register at the current address, and the address then increments by one.
- R4: A two-byte transaction (command byte, then one data byte) writes exactly one register.
- R5: MISO is 0 throughout the command byte and throughout every byte slot of a write burst.
- R6: An address that increments past 0x3F wraps to 0x00, in both read and write bursts.
- R7: Start addresses 0x40 to 0x7F are reduced to their low 6 bits. For example, 0x45 accesses register 0x05.
- R8: If chip-select deasserts before a byte is complete, that partial byte is discarded and no register changes.
- R9: Each new chip-select window starts in the command phase, even when the previous window ended part-way through a byte.
- R10: The system read port returns the register selected by `sys_raddr` in the same cycle.
- R11: Bytes move most significant bit first in both directions. Register values 0x80 and 0x01 therefore arrive and leave unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the master, idles low |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low chip-select |
| miso | output | 1 | Serial data to the master, held at 0 when not sending |
| sys_raddr | input | 6 | System-side register read address |
| sys_rdata | output | 8 | Contents of the register at `sys_raddr` |

## Verification
The bench sends these transaction shapes:
- a single two-byte write;
- multi-byte write and read bursts from mid-range addresses;
- bursts that start at 0x3E so they cross the wrap point;
- commands that name addresses above 0x3F;
- windows cut off after a few bits, either in the data phase or in the command byte itself.

Each shape exposes a different fault:
- the burst shapes separate correct auto-increment from a fixed address;
- the 0x3E start exposes a missing wrap;
- the high addresses expose unmasked address bits;
- the truncated windows expose a partial byte that gets written, and a command phase that is not restarted.

Byte values 0x80, 0x01 and alternating patterns reveal a reversed bit order. A behavioural model checks the system read port against its own register image on every idle clock.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
    typedef enum logic [1:0] {
        PH_CMD = 2'd0,
        PH_WR  = 2'd1,
        PH_RD  = 2'd2
    } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= async_i[i];
                s2_q <= s1_q;
            end
        end
        assign sync_o[i] = s2_q;
    end
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] spi_addr,
    output logic [BYTE_W-1:0] spi_rdata,
    input  logic [ADDR_W-1:0] sys_addr,
    output logic [BYTE_W-1:0] sys_rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem_d [DEPTH];
    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign spi_rdata = mem_q[spi_addr];
    assign sys_rdata = mem_q[sys_addr];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_n_s,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              miso,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cs_act,
    output phase_e            phase
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic [ADDR_W-1:0] addr;
        logic              sclk_prev;
    } eng_t;

    eng_t st_d, st_q;
    logic rise, fall;
    logic [BYTE_W-1:0] byte_full;

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        rise      = sclk_s & ~st_q.sclk_prev;
        fall      = ~sclk_s & st_q.sclk_prev;
        byte_full = {st_q.rx[BYTE_W-2:0], mosi_s};
        st_d.sclk_prev = sclk_s;
        if (cs_n_s) begin
            st_d.phase = PH_CMD;
            st_d.cnt   = '0;
            st_d.rx    = '0;
            st_d.tx    = '0;
        end else if (rise) begin
            st_d.rx  = byte_full;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                unique case (st_q.phase)
                    PH_CMD: begin
                        st_d.addr  = byte_full[ADDR_W-1:0];
                        st_d.phase = byte_full[BYTE_W-1] ? PH_RD : PH_WR;
                    end
                    PH_WR: begin
                        wr_en     = 1'b1;
                        st_d.addr = st_q.addr + 1'b1;
                    end
                    default: ;
                endcase
            end
        end else if (fall) begin
            if (st_q.phase == PH_RD && st_q.cnt == '0) begin
                st_d.tx   = rd_data;
                st_d.addr = st_q.addr + 1'b1;
            end else begin
                st_d.tx = {st_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_CMD, default: '0};
        else        st_q <= st_d;
    end

    assign miso     = st_q.tx[BYTE_W-1];
    assign wr_data  = byte_full;
    assign cur_addr = st_q.addr;
    assign cs_act   = ~cs_n_s;
    assign phase    = st_q.phase;
endmodule

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave
    import spi_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              cs_n,
    output logic              miso,
    input  logic [ADDR_W-1:0] sys_raddr,
    output logic [BYTE_W-1:0] sys_rdata
);
    logic [2:0]        pins_s;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] spi_rdata;
    logic [ADDR_W-1:0] cur_addr;
    logic              cs_act;
    phase_e            phase;

    spi_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk, mosi, cs_n}),
        .sync_o  (pins_s)
    );

    spi_byte_engine #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[2]),
        .mosi_s   (pins_s[1]),
        .cs_n_s   (pins_s[0]),
        .rd_data  (spi_rdata),
        .miso     (miso),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cur_addr (cur_addr),
        .cs_act   (cs_act),
        .phase    (phase)
    );

    spi_regbank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (cur_addr),
        .wr_data   (wr_data),
        .spi_addr  (cur_addr),
        .spi_rdata (spi_rdata),
        .sys_addr  (sys_raddr),
        .sys_rdata (sys_rdata)
    );
endmodule

// File: rtl/spi_regfile_slave_chk.sv
module spi_regfile_slave_chk
    import spi_reg_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input phase_e            phase,
    input logic              miso,
    input logic              wr_en,
    input logic [ADDR_W-1:0] cur_addr
);
    a_r9_cmd_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_act) |-> phase == PH_CMD);

    a_r5_miso_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) |-> !miso);

    a_r5_miso_quiet_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WR) |-> !miso);

    a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !wr_en);

    a_r2_write_in_wr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> phase == PH_WR);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));
endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .phase    (phase),
    .miso     (miso),
    .wr_en    (wr_en),
    .cur_addr (cur_addr)
);

// File: tb/spi_regfile_slave_tb.sv
module spi_regfile_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       miso;
    logic [5:0] sys_raddr = '0;
    logic [7:0] sys_rdata;

    int compared = 0;
    int mismatched = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [7:0] ref_mem [64];
    logic [7:0] tx_q [$];
    logic [7:0] rx_q [$];
    logic [7:0] tail_pat = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regfile_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .sys_raddr(sys_raddr), .sys_rdata(sys_rdata)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Master side: full bytes from tx_q, then tail_bits bits of tail_pat.
    task automatic xfer(input int tail_bits);
        logic [7:0] b;
        quiet = 1'b0;
        rx_q.delete();
        clocks(2);
        cs_n = 1'b0;
        clocks(6);
        foreach (tx_q[i]) begin
            b = '0;
            for (int k = 7; k >= 0; k--) begin
                mosi = tx_q[i][k];
                clocks(HALF);
                sclk = 1'b1;
                b[k] = miso;
                clocks(HALF);
                sclk = 1'b0;
            end
            rx_q.push_back(b);
        end
        for (int k = 0; k < tail_bits; k++) begin
            mosi = tail_pat[7-k];
            clocks(HALF);
            sclk = 1'b1;
            clocks(HALF);
            sclk = 1'b0;
        end
        clocks(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        clocks(6);
    endtask

    // Reference model: apply one finished transaction and check MISO bytes.
    task automatic model_and_check(input string req);
        logic [5:0] a;
        logic       rd;
        if (tx_q.size() == 0) return;
        a  = tx_q[0][5:0];
        rd = tx_q[0][7];
        for (int i = 0; i < tx_q.size(); i++) begin
            if (i == 0) begin
                chk("R5", "miso during command byte", rx_q[i], 8'h00);
            end else if (rd) begin
                chk(req, "read byte", rx_q[i], ref_mem[a]);
                a = a + 1'b1;
            end else begin
                chk("R5", "miso during write byte", rx_q[i], 8'h00);
                ref_mem[a] = tx_q[i];
                a = a + 1'b1;
            end
        end
    endtask

    task automatic run(input string req, input int tail_bits);
        cur_req = req;
        xfer(tail_bits);
        model_and_check(req);
        quiet = 1'b1;
        clocks(70);
    endtask

    // Every-clock comparison of the system read port against the model.
    initial begin
        forever begin
            @(negedge clk);
            if (quiet && !done) begin
                chk({cur_req, "/R10"}, $sformatf("sys reg %02h", sys_raddr), sys_rdata, ref_mem[sys_raddr]);
                sys_raddr = sys_raddr + 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;
        clocks(4);
        rst_n = 1'b1;
        clocks(2);
        chk("R1", "miso after reset", {7'd0, miso}, 8'h00);
        cur_req = "R1";
        quiet = 1'b1;
        clocks(70);

        tx_q = '{8'h05, 8'hA5};
        run("R4", 0);

        tx_q = '{8'h10, 8'h11, 8'h22, 8'h33, 8'h44};
        run("R2", 0);

        tx_q = '{8'h8F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run("R3", 0);

        tx_q = '{8'h3E, 8'h5A, 8'hC3, 8'h69, 8'h96};
        run("R6", 0);

        tx_q = '{8'hBE, 8'h00, 8'h00, 8'h00, 8'h00};
        run("R6", 0);

        tx_q = '{8'h45, 8'h7E};
        run("R7", 0);

        tx_q = '{8'hC5, 8'h00, 8'h00};
        run("R7", 0);

        tx_q = '{8'h20, 8'h80, 8'h01};
        run("R11", 0);

        tx_q = '{8'hA0, 8'h00, 8'h00};
        run("R11", 0);

        tx_q = '{8'h28, 8'h3C};
        tail_pat = 8'hFF;
        run("R8", 5);

        tx_q = '{8'h29};
        run("R8", 7);

        tx_q = '{};
        tail_pat = 8'hB5;
        run("R9", 3);

        tx_q = '{8'h30, 8'hE7, 8'h18};
        run("R9", 0);

        tx_q = '{8'hB0, 8'h00, 8'h00};
        run("R9", 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule